// File: doc/BRIEF.md
# SPI Slave Pause Controller

This block sits between the pins of an SPI slave and its command sequencer. It lets the bus master pause a transaction without deselecting the slave. While the pause input is low, the block stops passing serial clock edges to the sequencer, takes the serial output off the bus and leaves the bit position unchanged. Once the pause is released, shifting carries on at the exact bit where it stopped. Both entry to and exit from the pause are aligned to the low phase of the serial clock. A pause request made while the clock is high takes effect only when the clock next goes low.

The three pins (select, serial clock, pause) are oversampled by a system clock through a synchronizer of configurable depth. All decisions are then made in that clock domain. The attached sequencer receives a one-cycle shift strobe for each serial clock rising edge that is allowed through. It also sees the current bit index within the transfer unit, a pause indicator and an output-enable for the serial data driver. Deselecting the slave during a pause resets this internal sequencing.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, `hold_active`, `so_oe`, `shift_enable` and `so_out` are 0 and `bit_pos` is 0.
- R2: While selected (`ce_n` low) and not paused, each rising edge of `sck` produces exactly one one-cycle `shift_enable` pulse. Each pulse also advances `bit_pos` by one, modulo 2^BIT_W, so with the default BIT_W of 3 the value after 8 edges is 0. In this state `so_oe` is 1 and `so_out` equals `so_data`.
- R3: If `hold_n` falls while `ce_n` is low and `sck` is low, `hold_active` becomes 1 without waiting for further `sck` activity.
- R4: If `hold_n` falls while `sck` is high, `hold_active` stays 0 until `sck` next goes low, and becomes 1 then.
- R5: If `hold_n` rises while `sck` is low, `hold_active` returns to 0. If `hold_n` rises while `sck` is high, `hold_active` stays 1 until `sck` next goes low.
- R6: While `hold_active` is 1, `so_oe` and `so_out` are 0 (serial output high impedance), and `sck` edges produce no `shift_enable` pulse and leave `bit_pos` unchanged.
- R7: After a pause ends, the next `sck` rising edge advances `bit_pos` from the value it held when the pause began.
- R8: Driving `ce_n` high, including during a pause, clears `hold_active`, `so_oe` and `bit_pos` to 0.
- R9: If `ce_n` falls while `hold_n` is low, the block starts paused (`hold_active` 1, no shifting). Shifting becomes possible only after `hold_n` is high while `sck` is low.
- R10: While `ce_n` is high, `hold_n` has no effect: `hold_active` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Slave select pin, active low |
| sck | input | 1 | Serial clock pin |
| hold_n | input | 1 | Pause request pin, active low |
| so_data | input | 1 | Serial output bit from the sequencer |
| so_out | output | 1 | Serial output data toward the pad, 0 when not driven |
| so_oe | output | 1 | Serial output pad driver enable; 0 means high impedance |
| hold_active | output | 1 | Transaction is paused |
| shift_enable | output | 1 | One-cycle strobe allowing the sequencer to shift one bit |
| bit_pos | output | BIT_W | Bit index within the current transfer unit |

## Verification
A pin change reaches the registered outputs on the third rising `clk` edge after it is applied: two synchronizer stages, then one edge for the state and strobe registers. The one exception is `so_out`, which also follows `so_data` combinationally. Each scenario task drives pins on a falling `clk` edge and waits four falling edges before sampling, so every check falls one edge after the result is due. `shift_enable` pulses are counted by a bench monitor on each rising edge. This lets checks on ignored edges compare the pulse count and `bit_pos` against their values from before the stimulus.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_PAUSED = 2'd2
   } hold_state_e;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
   parameter int STAGES = 2,
   parameter int W = 3,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
            end else begin
               pipe[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q = pipe[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
   import spi_hold_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ce_n_s,
   input  logic        sck_s,
   input  logic        hold_n_s,
   output hold_state_e state,
   output logic        sck_rise
);
   hold_state_e nxt;
   logic        sck_q;

   assign sck_rise = sck_s & ~sck_q;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE: begin
            if (!ce_n_s) nxt = hold_n_s ? ST_ACTIVE : ST_PAUSED;
         end
         ST_ACTIVE: begin
            if (ce_n_s) nxt = ST_IDLE;
            else if (!hold_n_s && !sck_s) nxt = ST_PAUSED;
         end
         ST_PAUSED: begin
            if (ce_n_s) nxt = ST_IDLE;
            else if (hold_n_s && !sck_s) nxt = ST_ACTIVE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sck_q <= 1'b0;
      end else begin
         state <= nxt;
         sck_q <= sck_s;
      end
   end
endmodule

// File: rtl/hold_shift_gate.sv
module hold_shift_gate
   import spi_hold_pkg::*;
#(
   parameter int BIT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  hold_state_e      state,
   input  logic             ce_n_s,
   input  logic             sck_rise,
   output logic             shift_en,
   output logic [BIT_W-1:0] bit_cnt
);
   logic pass;
   assign pass = (state == ST_ACTIVE) && !ce_n_s && sck_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_en <= 1'b0;
         bit_cnt  <= '0;
      end else begin
         shift_en <= pass;
         if (ce_n_s || state == ST_IDLE) bit_cnt <= '0;
         else if (pass) bit_cnt <= bit_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
   import spi_hold_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BIT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             sck,
   input  logic             hold_n,
   input  logic             so_data,
   output logic             so_out,
   output logic             so_oe,
   output logic             hold_active,
   output logic             shift_enable,
   output logic [BIT_W-1:0] bit_pos
);
   localparam int PINS = 3;
   localparam logic [PINS-1:0] PIN_RST = 3'b101; // ce_n, sck, hold_n idle levels

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
      if (BIT_W < 1 || BIT_W > 8) begin : g_bad_bits
         $error("BIT_W must lie in 1..8");
      end
   endgenerate

   logic [PINS-1:0] pins_s;
   logic            ce_n_s, sck_s, hold_n_s, sck_rise;
   hold_state_e     state;

   hold_sync #(.STAGES(SYNC_STAGES), .W(PINS), .RST_VAL(PIN_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({ce_n, sck, hold_n}), .q(pins_s)
   );
   assign {ce_n_s, sck_s, hold_n_s} = pins_s;

   hold_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .ce_n_s(ce_n_s), .sck_s(sck_s),
      .hold_n_s(hold_n_s), .state(state), .sck_rise(sck_rise)
   );

   hold_shift_gate #(.BIT_W(BIT_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .state(state), .ce_n_s(ce_n_s),
      .sck_rise(sck_rise), .shift_en(shift_enable), .bit_cnt(bit_pos)
   );

   assign hold_active = (state == ST_PAUSED);
   assign so_oe       = (state == ST_ACTIVE);
   assign so_out      = so_oe & so_data;
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk #(
   parameter int BIT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ce_n_s,
   input logic             sck_s,
   input logic             hold_n_s,
   input logic             hold_active,
   input logic             so_oe,
   input logic             so_out,
   input logic             shift_enable,
   input logic [BIT_W-1:0] bit_pos
);
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_enable |-> bit_pos == BIT_W'($past(bit_pos) + 1'b1));
   p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_enable |=> !shift_enable);
   p_enter_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (so_oe && !ce_n_s && !hold_n_s && !sck_s) |=> hold_active);
   p_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_active && sck_s) |=> !hold_active);
   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> (!so_oe && !so_out && !shift_enable));
   p_keep_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_active && !ce_n_s) |=> $stable(bit_pos));
   p_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n_s |=> (!hold_active && !so_oe && bit_pos == '0));
endmodule

bind spi_hold_ctrl spi_hold_chk #(.BIT_W(BIT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n_s(ce_n_s), .sck_s(sck_s),
   .hold_n_s(hold_n_s), .hold_active(hold_active), .so_oe(so_oe),
   .so_out(so_out), .shift_enable(shift_enable), .bit_pos(bit_pos)
);

// File: tb/sim_spi_hold_ctrl.sv
module sim_spi_hold_ctrl;
   localparam int BIT_W = 3;
   localparam int SETTLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, sck = 1'b0, hold_n = 1'b1, so_data = 1'b0;
   logic so_out, so_oe, hold_active, shift_enable;
   logic [BIT_W-1:0] bit_pos;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   spi_hold_ctrl #(.SYNC_STAGES(2), .BIT_W(BIT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sck(sck), .hold_n(hold_n),
      .so_data(so_data), .so_out(so_out), .so_oe(so_oe),
      .hold_active(hold_active), .shift_enable(shift_enable), .bit_pos(bit_pos)
   );

   always @(posedge clk) if (shift_enable) pulses <= pulses + 1;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(negedge clk);
   endtask

   task automatic sck_pulse();
      sck = 1'b1; settle();
      sck = 1'b0; settle();
   endtask

   task automatic t_reset();
      chk("R1", "hold_active", hold_active, 0);
      chk("R1", "so_oe", so_oe, 0);
      chk("R1", "shift_enable", shift_enable, 0);
      chk("R1", "so_out", so_out, 0);
      chk("R1", "bit_pos", bit_pos, 0);
   endtask

   task automatic t_shift();
      int p0;
      ce_n = 1'b0; settle();
      so_data = 1'b1; #1;
      chk("R2", "so_oe", so_oe, 1);
      chk("R2", "so_out", so_out, 1);
      p0 = pulses;
      for (int i = 0; i < 3; i++) sck_pulse();
      chk("R2", "pulses", pulses - p0, 3);
      chk("R2", "bit_pos", bit_pos, 3);
   endtask

   task automatic t_hold_sck_low();
      int p0;
      hold_n = 1'b0; settle();
      chk("R3", "hold_active", hold_active, 1);
      chk("R6", "so_oe", so_oe, 0);
      chk("R6", "so_out", so_out, 0);
      p0 = pulses;
      sck_pulse(); sck_pulse();
      chk("R6", "pulses", pulses - p0, 0);
      chk("R6", "bit_pos", bit_pos, 3);
      chk("R6", "hold_active", hold_active, 1);
      hold_n = 1'b1; settle();
      chk("R5", "hold_active", hold_active, 0);
      sck_pulse();
      chk("R7", "bit_pos", bit_pos, 4);
   endtask

   task automatic t_hold_sck_high();
      sck = 1'b1; settle();
      chk("R2", "bit_pos", bit_pos, 5);
      hold_n = 1'b0; settle();
      chk("R4", "hold_active", hold_active, 0);
      sck = 1'b0; settle();
      chk("R4", "hold_active", hold_active, 1);
      sck = 1'b1; settle();
      hold_n = 1'b1; settle();
      chk("R5", "hold_active", hold_active, 1);
      chk("R6", "bit_pos", bit_pos, 5);
      sck = 1'b0; settle();
      chk("R5", "hold_active", hold_active, 0);
      sck_pulse();
      chk("R7", "bit_pos", bit_pos, 6);
   endtask

   task automatic t_deselect();
      int p0;
      hold_n = 1'b0; settle();
      chk("R3", "hold_active", hold_active, 1);
      ce_n = 1'b1; settle();
      chk("R8", "hold_active", hold_active, 0);
      chk("R8", "bit_pos", bit_pos, 0);
      chk("R8", "so_oe", so_oe, 0);
      settle();
      chk("R10", "hold_active", hold_active, 0);
      ce_n = 1'b0; settle();
      chk("R9", "hold_active", hold_active, 1);
      p0 = pulses;
      sck_pulse();
      chk("R9", "pulses", pulses - p0, 0);
      chk("R9", "bit_pos", bit_pos, 0);
      hold_n = 1'b1; settle();
      chk("R9", "hold_active", hold_active, 0);
      sck_pulse();
      chk("R9", "bit_pos", bit_pos, 1);
   endtask

   task automatic t_wrap();
      int p0;
      ce_n = 1'b1; settle();
      ce_n = 1'b0; settle();
      p0 = pulses;
      for (int i = 0; i < 8; i++) sck_pulse();
      chk("R2", "wrap pulses", pulses - p0, 8);
      chk("R2", "wrap bit_pos", bit_pos, 0);
      ce_n = 1'b1; settle();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      t_shift();
      t_hold_sck_low();
      t_hold_sck_high();
      t_deselect();
      t_wrap();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule